// File: doc/BRIEF.md
# Satellite Sound Tuner Control Port

This block is a write-only two-wire bus target. It lets a host processor load the two settings of a sound-carrier converter: the ratio of its synthesizer divider and a word of IF and audio control bits. The block watches SCL and SDA with the system clock and frames each telegram between a start and a stop condition. It compares the first byte with its own 7-bit address, where one address bit comes from a strap pin, and pulls SDA low on the ninth clock of every byte it accepts.

After the address, the data bytes are taken two at a time. The most significant bit of the first byte in each pair says which register the pair is for. The remaining seven bits of that byte and all eight bits of the second byte form a 15-bit value. That value is written into its register only once the second byte has been acknowledged. A half-received pair is dropped. Two of these blocks can sit on one bus by strapping the select pin differently.

Top module: `telegram_slave`

## Requirements
- R1: A telegram opens with SDA falling while SCL is high and closes with SDA rising while SCL is high. Bytes clocked while no telegram is open get no acknowledge and leave both registers unchanged.
- R2: Bits 7:1 of the first byte are compared with {ADDR_HI, addr_sel}, and bit 0 must be 0 (write). With the default ADDR_HI = 6'b110000 the accepted first byte is 0xC0 when addr_sel=0 and 0xC2 when addr_sel=1.
- R3: For an accepted address byte and for each data byte after it, sda_oe is high from the SCL fall that ends bit 8 until the SCL fall that ends the ninth clock. sda_oe only changes while SCL is low.
- R4: On an address mismatch or a direction bit of 1, the block gives no acknowledge, acknowledges none of the following bytes, and changes no register until the next start.
- R5: Data bytes form pairs (bytes 1+2, bytes 3+4, ...). If bit 7 of the first byte of a pair is 0, div_ratio becomes {first[6:0], second}.
- R6: If bit 7 of the first byte of a pair is 1, ctrl_word becomes {first[6:0], second}.
- R7: Each pair is typed on its own, so one four-byte telegram can update both registers. No single commit changes both registers.
- R8: A pair is committed only after its second byte has been acknowledged. A stop or a repeated start that follows the first byte of a pair discards that byte.
- R9: While rst is high, sda_oe is 0 and both registers read 0. sda_oe stays 0 after rst falls until a new address byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset, also the power-on hold |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel | input | 1 | Strap that sets the address LSB |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| div_ratio | output | 15 | Divider ratio register |
| ctrl_word | output | 15 | IF/audio control register |

## Verification
The release of the acknowledge happens on the SCL fall that ends the ninth clock. The same fall restarts the bit counter, and the host may put the next data bit or the set-up for a repeated start on SDA straight after it. The bench provokes this by putting the repeated start right after a one-byte pair has been acknowledged. It then judges that the dropped half-pair never reaches a register, and that the address byte of the new telegram is acknowledged again. The mirror case comes from asserting reset in the middle of an acknowledge: sda_oe must drop at once and both registers must clear.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W - 1;
    localparam int ADDR_W   = 7;
    localparam int BITCNT_W = $clog2(BYTE_W + 2);

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_DATA,
        BUS_SKIP
    } bus_state_e;

    typedef enum logic {
        KIND_DIV  = 1'b0,
        KIND_CTRL = 1'b1
    } pair_kind_e;

    typedef struct packed {
        logic                valid;
        pair_kind_e          kind;
        logic [BYTE_W-2:0]   upper;
    } half_pair_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-2:0] hi,
                                      input logic sel);
        return (b[BYTE_W-1:1] == {hi, sel}) && !b[0];
    endfunction

endpackage

// File: rtl/tlg_sync.sv
module tlg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_d  <= scl_sr[STAGES-1];
            sda_d  <= sda_sr[STAGES-1];
        end
    end

    assign scl_now   = scl_sr[STAGES-1];
    assign sda_lvl   = sda_sr[STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/tlg_byte_rx.sv
module tlg_byte_rx
    import tlg_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI = 6'b110000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    output logic              ack_q,
    output logic              byte_stb,
    output logic              frame_open,
    output logic [BYTE_W-1:0] byte_q
);
    bus_state_e          state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic                active;

    assign active = (state == BUS_ADDR) || (state == BUS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= BUS_IDLE;
            bit_cnt    <= '0;
            byte_q     <= '0;
            ack_q      <= 1'b0;
            byte_stb   <= 1'b0;
            frame_open <= 1'b0;
        end else begin
            byte_stb   <= 1'b0;
            frame_open <= 1'b0;
            if (start_det) begin
                state      <= BUS_ADDR;
                bit_cnt    <= '0;
                ack_q      <= 1'b0;
                frame_open <= 1'b1;
            end else if (stop_det) begin
                state   <= BUS_IDLE;
                bit_cnt <= '0;
                ack_q   <= 1'b0;
            end else if (active) begin
                if (scl_rise) begin
                    if (bit_cnt < BITCNT_W'(BYTE_W)) begin
                        byte_q  <= {byte_q[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (bit_cnt == BITCNT_W'(BYTE_W)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (state == BUS_DATA && ack_q)
                            byte_stb <= 1'b1;
                    end
                end else if (scl_fall) begin
                    if (bit_cnt == BITCNT_W'(BYTE_W)) begin
                        if (state == BUS_DATA || addr_hit(byte_q, ADDR_HI, addr_sel))
                            ack_q <= 1'b1;
                        else
                            state <= BUS_SKIP;
                    end else if (bit_cnt == BITCNT_W'(BYTE_W + 1)) begin
                        ack_q   <= 1'b0;
                        bit_cnt <= '0;
                        state   <= BUS_DATA;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tlg_pair_steer.sv
module tlg_pair_steer
    import tlg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic              frame_open,
    input  logic [BYTE_W-1:0] byte_q,
    output logic [WORD_W-1:0] div_ratio,
    output logic [WORD_W-1:0] ctrl_word
);
    half_pair_t half;

    always_ff @(posedge clk) begin
        if (rst) begin
            half      <= '0;
            div_ratio <= '0;
            ctrl_word <= '0;
        end else if (frame_open) begin
            half.valid <= 1'b0;
        end else if (byte_stb) begin
            if (!half.valid) begin
                half.valid <= 1'b1;
                half.kind  <= pair_kind_e'(byte_q[BYTE_W-1]);
                half.upper <= byte_q[BYTE_W-2:0];
            end else begin
                half.valid <= 1'b0;
                if (half.kind == KIND_DIV)
                    div_ratio <= {half.upper, byte_q};
                else
                    ctrl_word <= {half.upper, byte_q};
            end
        end
    end
endmodule

// File: rtl/telegram_slave.sv
module telegram_slave
    import tlg_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b110000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [WORD_W-1:0] div_ratio,
    output logic [WORD_W-1:0] ctrl_word
);
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              ack_q, byte_stb, frame_open;
    logic [BYTE_W-1:0] byte_q;

    tlg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tlg_byte_rx #(.ADDR_HI(ADDR_HI)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_sel   (addr_sel),
        .ack_q      (ack_q),
        .byte_stb   (byte_stb),
        .frame_open (frame_open),
        .byte_q     (byte_q)
    );

    tlg_pair_steer u_steer (
        .clk        (clk),
        .rst        (rst),
        .byte_stb   (byte_stb),
        .frame_open (frame_open),
        .byte_q     (byte_q),
        .div_ratio  (div_ratio),
        .ctrl_word  (ctrl_word)
    );

    // power-on hold: never pull the line while reset is present
    assign sda_oe = ack_q & ~rst;
endmodule

// File: rtl/tlg_checker.sv
module tlg_checker #(
    parameter int W = 15
) (
    input logic         clk,
    input logic         rst,
    input logic         scl_i,
    input logic         sda_oe,
    input logic [W-1:0] div_ratio,
    input logic [W-1:0] ctrl_word
);
    // R3
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R3
    oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_i);

    // R9
    oe_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sda_oe);

    // R5
    div_commit_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_ratio) |-> scl_i);

    // R6
    ctrl_commit_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> scl_i);

    // R7
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_ratio) |-> $stable(ctrl_word));
endmodule

bind telegram_slave tlg_checker #(.W(tlg_pkg::WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .div_ratio (div_ratio),
    .ctrl_word (ctrl_word)
);

// File: tb/telegram_slave_bench.sv
module telegram_slave_bench;
    localparam int Q  = 40;
    localparam int NV = 10;
    localparam int W  = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         addr_sel = 1'b0;
    logic         sda_oe;
    logic         sda_line;
    logic [W-1:0] div_ratio, ctrl_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    telegram_slave u_telegram_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .div_ratio (div_ratio),
        .ctrl_word (ctrl_word)
    );

    // bytes left-aligned, byte 0 in [39:32]
    localparam logic [39:0] VB [NV] = '{
        40'hC004000000, 40'hC087FF0000, 40'hC007FF855A, 40'hC083210210,
        40'hC201020000, 40'hC205550000, 40'hC305660000, 40'hC286000000,
        40'hC07FFF8100, 40'hC000000000 };
    localparam logic [2:0]   VN   [NV] = '{3, 3, 5, 5, 3, 3, 3, 2, 4, 1};
    localparam logic         VS   [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
    localparam logic [W-1:0] VDIV [NV] = '{15'h0400, 15'h0400, 15'h07FF, 15'h0210,
        15'h0210, 15'h0555, 15'h0555, 15'h0555, 15'h7FFF, 15'h7FFF};
    localparam logic [W-1:0] VCTL [NV] = '{15'h0000, 15'h07FF, 15'h055A, 15'h0321,
        15'h0321, 15'h0321, 15'h0321, 15'h0321, 15'h0321, 15'h0321};
    localparam logic [4:0]   VACK [NV] = '{5'b00111, 5'b00111, 5'b11111, 5'b11111,
        5'b00000, 5'b00111, 5'b00000, 5'b00011, 5'b01111, 5'b00000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        m_sda = 1'b0; wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        m_sda = 1'b1; wt(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(Q);
            scl = 1'b1;   wt(2 * Q);
            scl = 1'b0;   wt(Q);
        end
        m_sda = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b);
        wt(Q);
        scl = 1'b1; wt(Q);
        ack = !sda_line;
        wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        wt(10);
        // R9: reset state
        chk("R9 oe in reset", 32'(sda_oe), 0);
        chk("R9 div in reset", 32'(div_ratio), 0);
        chk("R9 ctrl in reset", 32'(ctrl_word), 0);
        rst = 1'b0;
        wt(Q);

        for (int v = 0; v < NV; v++) begin
            addr_sel = VS[v];
            wt(Q);
            bus_start();
            for (int k = 0; k < int'(VN[v]); k++) begin
                send_byte(VB[v][39 - 8 * k -: 8], a);
                // R2 R3 R4 acknowledge per byte
                chk($sformatf("R3/R4 vec%0d byte%0d ack", v, k), 32'(a), 32'(VACK[v][k]));
            end
            bus_stop();
            // R5 R6 R7 R8 register contents
            chk($sformatf("R5 vec%0d div", v), 32'(div_ratio), 32'(VDIV[v]));
            chk($sformatf("R6 vec%0d ctrl", v), 32'(ctrl_word), 32'(VCTL[v]));
        end

        // R8: repeated start after half a pair drops it
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'hC0, a); chk("R2 rs addr ack", 32'(a), 1);
        send_byte(8'h04, a); chk("R3 rs half ack", 32'(a), 1);
        bus_start();
        send_byte(8'hC0, a); chk("R8 re-addr ack", 32'(a), 1);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        bus_stop();
        chk("R8 div after repeated start", 32'(div_ratio), 32'h1234);
        chk("R8 ctrl after repeated start", 32'(ctrl_word), 32'h0321);

        // R1: bytes without a start are ignored
        scl = 1'b0; wt(Q);
        send_byte(8'hC0, a); chk("R1 no-start addr ack", 32'(a), 0);
        send_byte(8'h01, a); chk("R1 no-start data ack", 32'(a), 0);
        send_byte(8'h02, a);
        bus_stop();
        chk("R1 div unchanged", 32'(div_ratio), 32'h1234);

        // R9: reset in the middle of an acknowledge
        bus_start();
        send_bits(8'hC0);
        wt(Q);
        chk("R3 oe during ack", 32'(sda_oe), 1);
        rst = 1'b1;
        wt(1);
        chk("R9 oe cut by reset", 32'(sda_oe), 0);
        wt(3);
        chk("R9 div cleared", 32'(div_ratio), 0);
        chk("R9 ctrl cleared", 32'(ctrl_word), 0);
        rst = 1'b0;
        scl = 1'b1; wt(Q);
        chk("R9 oe after release", 32'(sda_oe), 0);
        scl = 1'b0; wt(Q);
        bus_stop();
        chk("R9 oe idle", 32'(sda_oe), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule